// File: doc/BRIEF.md
# 16-bit Address Arithmetic Unit

This unit does the 16-bit register arithmetic of an 8-bit CPU in one combinational step. It handles five operations. It adds a register pair to the HL pair. It increments or decrements a register pair. It adds a signed 8-bit displacement to the stack pointer, and that sum goes either back to SP or into HL. The datapath gives the unit its operands and the current flag nibble. The unit returns the 16-bit result, the new flag nibble, and a destination code that tells the writeback stage which register receives the result.

The flag rules depend on the operation. The pair add keeps Z. The displacement add clears Z and N. Increment and decrement pass the incoming flags through unchanged. Writeback, memory access and instruction timing are outside this block.

Operation codes on `op_sel` are as follows: 0 is HL plus pair, 1 is increment, 2 is decrement, 3 is SP plus displacement into SP, and 4 is SP plus displacement into HL. Codes 5 to 7 are unused. The flag nibble is laid out as bit 3 = Z, bit 2 = N, bit 1 = H and bit 0 = C. Destination codes on `dest` are 0 = HL, 1 = SP, 2 = the pair given on `opnd_a`, and 3 = none.

Top module: `addr_arith_unit`

## Requirements
- R1: With op 0, `result` is (`opnd_a` + `opnd_b`) mod 65536 and `dest` is 0 (HL).
- R2: With op 0, flag bit 3 (Z) equals `flags_in` bit 3, and bit 2 (N) is 0. Bit 1 (H) is the carry out of bit 11 of the sum, and bit 0 (C) is the carry out of bit 15.
- R3: With op 1, `result` is (`opnd_a` + 1) mod 65536, so 0xFFFF becomes 0x0000, and `dest` is 2.
- R4: With op 2, `result` is (`opnd_a` − 1) mod 65536, so 0x0000 becomes 0xFFFF, and `dest` is 2.
- R5: With op 1 or op 2, `flags_out` equals `flags_in` on all four bits.
- R6: With op 3 or op 4, `result` is `opnd_a` plus `disp` sign-extended to 16 bits, mod 65536. A `disp` of 0x80 to 0xFF moves the value down.
- R7: With op 3 or op 4, Z and N are 0. H is the carry out of bit 3 and C is the carry out of bit 7 of the unsigned sum of `opnd_a[7:0]` and the raw `disp` byte.
- R8: Op 3 gives `dest` 1 (SP) and op 4 gives `dest` 0 (HL). For equal inputs, both give the same result and the same flags.
- R9: Op codes 5 to 7 give `result` equal to `opnd_a`, `flags_out` equal to `flags_in`, and `dest` 3 (none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code (0 to 4 defined) |
| opnd_a | input | 16 | HL for op 0, the pair for ops 1 and 2, SP for ops 3 and 4 |
| opnd_b | input | 16 | Pair added to HL in op 0 |
| disp | input | 8 | Two's-complement displacement for ops 3 and 4 |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| result | output | 16 | Arithmetic result |
| flags_out | output | 4 | New flags {Z,N,H,C} |
| dest | output | 2 | Destination register code |

## Verification
The unit is combinational, so a fault shows on the ports while the faulty input is still applied, in the same cycle. Two kinds of fault are likely. One takes a carry from the wrong bit position. The other applies the wrong flag rule to an operation. The vectors are chosen so that the bit-11 carry and the bit-15 carry occur separately, so that the bit-3 carry and the bit-7 carry occur separately, and so that each operation receives a flag nibble it must keep, clear or ignore. Either fault therefore changes `flags_out` on at least one vector. The wrap at 0x0000/0xFFFF and negative displacements exercise the sign-extension and modulo paths.

// File: rtl/addr_arith_pkg.sv
package addr_arith_pkg;

  localparam int FLAG_W = 4;
  localparam int FZ = 3;
  localparam int FN = 2;
  localparam int FH = 1;
  localparam int FC = 0;

  typedef enum logic [2:0] {
    OP_ADD_PAIR = 3'd0,
    OP_INC      = 3'd1,
    OP_DEC      = 3'd2,
    OP_SPD_SP   = 3'd3,
    OP_SPD_HL   = 3'd4
  } aop_e;

  typedef enum logic [1:0] {
    DST_HL   = 2'd0,
    DST_SP   = 2'd1,
    DST_PAIR = 2'd2,
    DST_NONE = 2'd3
  } dst_e;

  // Carry leaving bit top_bit when x and y are summed with carry-in cin.
  function automatic logic ripple_carry(input logic [31:0] x, input logic [31:0] y,
                                        input logic cin, input int top_bit);
    logic c;
    c = cin;
    for (int i = 0; i < 32; i++) begin
      if (i <= top_bit) c = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
    end
    return c;
  endfunction

endpackage

// File: rtl/hl_pair_adder.sv
module hl_pair_adder
  import addr_arith_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]      hl,
  input  logic [W-1:0]      pair,
  input  logic [FLAG_W-1:0] fin,
  output logic [W-1:0]      sum,
  output logic [FLAG_W-1:0] fout
);
  localparam int HC_BIT = (W * 3) / 4 - 1;

  logic half_cy;
  logic full_cy;

  always_comb begin
    sum     = hl + pair;
    half_cy = ripple_carry(32'(hl), 32'(pair), 1'b0, HC_BIT);
    full_cy = ripple_carry(32'(hl), 32'(pair), 1'b0, W - 1);
    fout    = '0;
    fout[FZ] = fin[FZ];
    fout[FN] = 1'b0;
    fout[FH] = half_cy;
    fout[FC] = full_cy;
  end

  always_comb begin
    // R2
    zero_keep_chk: assert (fout[FZ] == fin[FZ] && !fout[FN]);
  end
endmodule

// File: rtl/pair_stepper.sv
module pair_stepper #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         down,
  output logic [W-1:0] res
);
  always_comb res = down ? val - W'(1) : val + W'(1);

  always_comb begin
    // R3
    inc_wrap_chk: assert (down || !(&val) || res == '0);
    // R4
    dec_wrap_chk: assert (!down || (|val) || (&res));
  end
endmodule

// File: rtl/sp_disp_adder.sv
module sp_disp_adder
  import addr_arith_pkg::*;
#(
  parameter int W  = 16,
  parameter int DW = 8
) (
  input  logic [W-1:0]  sp,
  input  logic [DW-1:0] disp,
  output logic [W-1:0]  res,
  output logic          h_cy,
  output logic          c_cy
);
  localparam int EXT = W - DW;

  logic [W-1:0] disp_ext;

  always_comb begin
    disp_ext = {{EXT{disp[DW-1]}}, disp};
    res      = sp + disp_ext;
    h_cy     = ripple_carry(32'(sp[DW-1:0]), 32'(disp), 1'b0, DW / 2 - 1);
    c_cy     = ripple_carry(32'(sp[DW-1:0]), 32'(disp), 1'b0, DW - 1);
  end

  always_comb begin
    // R6
    disp_zero_chk: assert (|disp || res == sp);
  end
endmodule

// File: rtl/addr_arith_unit.sv
module addr_arith_unit
  import addr_arith_pkg::*;
#(
  parameter int W  = 16,
  parameter int DW = 8
) (
  input  logic [2:0]        op_sel,
  input  logic [W-1:0]      opnd_a,
  input  logic [W-1:0]      opnd_b,
  input  logic [DW-1:0]     disp,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [W-1:0]      result,
  output logic [FLAG_W-1:0] flags_out,
  output logic [1:0]        dest
);
  logic [W-1:0]      pair_sum;
  logic [FLAG_W-1:0] pair_flags;
  logic [W-1:0]      step_res;
  logic              step_down;
  logic [W-1:0]      spd_res;
  logic              spd_h;
  logic              spd_c;

  assign step_down = (op_sel == OP_DEC);

  hl_pair_adder #(.W(W)) u_pair (
    .hl(opnd_a), .pair(opnd_b), .fin(flags_in), .sum(pair_sum), .fout(pair_flags)
  );

  pair_stepper #(.W(W)) u_step (
    .val(opnd_a), .down(step_down), .res(step_res)
  );

  sp_disp_adder #(.W(W), .DW(DW)) u_spd (
    .sp(opnd_a), .disp(disp), .res(spd_res), .h_cy(spd_h), .c_cy(spd_c)
  );

  always_comb begin
    result    = opnd_a;
    flags_out = flags_in;
    dest      = DST_NONE;
    case (op_sel)
      OP_ADD_PAIR: begin
        result    = pair_sum;
        flags_out = pair_flags;
        dest      = DST_HL;
      end
      OP_INC, OP_DEC: begin
        result = step_res;
        dest   = DST_PAIR;
      end
      OP_SPD_SP, OP_SPD_HL: begin
        result    = spd_res;
        flags_out = '0;
        flags_out[FH] = spd_h;
        flags_out[FC] = spd_c;
        dest      = (op_sel == OP_SPD_SP) ? DST_SP : DST_HL;
      end
      default: ;
    endcase
  end

  always_comb begin
    // R5
    step_flag_chk: assert (!(op_sel == OP_INC || op_sel == OP_DEC) || flags_out == flags_in);
    // R7
    disp_zn_chk: assert (!(op_sel == OP_SPD_SP || op_sel == OP_SPD_HL) ||
                         (!flags_out[FZ] && !flags_out[FN]));
    // R8
    disp_dest_chk: assert (!(op_sel == OP_SPD_SP || op_sel == OP_SPD_HL) ||
                           dest == ((op_sel == OP_SPD_SP) ? DST_SP : DST_HL));
    // R9
    idle_pass_chk: assert (op_sel <= 3'd4 || (result == opnd_a && dest == DST_NONE));
  end
endmodule

// File: tb/tb_addr_arith_unit.sv
module tb_addr_arith_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0]  op_sel = 3'd7;
  logic [15:0] opnd_a = '0;
  logic [15:0] opnd_b = '0;
  logic [7:0]  disp = '0;
  logic [3:0]  flags_in = '0;
  logic [15:0] result;
  logic [3:0]  flags_out;
  logic [1:0]  dest;

  addr_arith_unit dut (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .disp(disp),
    .flags_in(flags_in), .result(result), .flags_out(flags_out), .dest(dest)
  );

  logic [21:0] exp_q[$];
  string       tag_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model written from the requirements: {result, flags, dest}
  function automatic logic [21:0] model(input logic [2:0] op, input logic [15:0] a,
                                        input logic [15:0] b, input logic [7:0] d,
                                        input logic [3:0] f);
    logic [16:0] s17;
    logic [15:0] r;
    logic [3:0]  fl;
    logic [1:0]  ds;
    int          lo;
    int          lo4;
    r = a; fl = f; ds = 2'd3;
    case (op)
      3'd0: begin
        s17 = {1'b0, a} + {1'b0, b};
        r = s17[15:0];
        fl = {f[3], 1'b0, ((a & 16'h0FFF) + (b & 16'h0FFF)) > 16'h0FFF, s17[16]};
        ds = 2'd0;
      end
      3'd1: begin r = (a == 16'hFFFF) ? 16'h0000 : a + 16'd1; ds = 2'd2; end
      3'd2: begin r = (a == 16'h0000) ? 16'hFFFF : a - 16'd1; ds = 2'd2; end
      3'd3, 3'd4: begin
        if (d[7]) r = a - {8'h00, (~d + 8'd1)};
        else      r = a + {8'h00, d};
        lo  = int'(a[7:0]) + int'(d);
        lo4 = int'(a[3:0]) + int'(d[3:0]);
        fl = {2'b00, lo4 > 15, lo > 255};
        ds = (op == 3'd3) ? 2'd1 : 2'd0;
      end
      default: ;
    endcase
    return {r, fl, ds};
  endfunction

  task automatic drive(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic [7:0] d, input logic [3:0] f, input string tag);
    @(posedge clk);
    #1;
    op_sel = op; opnd_a = a; opnd_b = b; disp = d; flags_in = f;
    exp_q.push_back(model(op, a, b, d, f));
    tag_q.push_back(tag);
  endtask

  // Monitor: compare at the falling edge, after inputs settled
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [21:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({result, flags_out, dest} !== e) begin
          errors++;
          $display("FAIL %s: got res=%h flg=%b dst=%0d, exp res=%h flg=%b dst=%0d",
                   t, result, flags_out, dest, e[21:6], e[5:2], e[1:0]);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R9: idle state, unused codes pass through
    drive(3'd7, 16'h1234, 16'h0000, 8'h00, 4'b1010, "R9");
    drive(3'd5, 16'hBEEF, 16'h1111, 8'h7F, 4'b0101, "R9");
    drive(3'd6, 16'h0000, 16'hFFFF, 8'h80, 4'b1111, "R9");
    // R1/R2: bit-11 carry only, bit-15 carry, both, Z kept, N cleared
    drive(3'd0, 16'h0FFF, 16'h0001, 8'h00, 4'b0100, "R2 h only");
    drive(3'd0, 16'h8000, 16'h8000, 8'h00, 4'b1101, "R2 c only");
    drive(3'd0, 16'hFFFF, 16'h0001, 8'h00, 4'b1100, "R2 h and c");
    drive(3'd0, 16'h1234, 16'h4321, 8'h00, 4'b0011, "R1 plain");
    // R3/R4/R5: wrap and flag passthrough
    drive(3'd1, 16'hFFFF, 16'h0000, 8'h00, 4'b1011, "R3 wrap");
    drive(3'd1, 16'h00FF, 16'h0000, 8'h00, 4'b0110, "R3");
    drive(3'd2, 16'h0000, 16'h0000, 8'h00, 4'b1111, "R4 wrap");
    drive(3'd2, 16'h0100, 16'h0000, 8'h00, 4'b0000, "R5");
    // R6/R7/R8
    drive(3'd3, 16'hFFF8, 16'h0000, 8'h08, 4'b1100, "R7 h and c");
    drive(3'd3, 16'h0000, 16'h0000, 8'hFF, 4'b1111, "R6 negative");
    drive(3'd3, 16'h1000, 16'h0000, 8'h80, 4'b1111, "R6 min disp");
    drive(3'd4, 16'h000F, 16'h0000, 8'h01, 4'b1100, "R7 h only");
    drive(3'd4, 16'h00F0, 16'h0000, 8'h10, 4'b0000, "R7 c only");
    drive(3'd4, 16'hFFF8, 16'h0000, 8'h08, 4'b1100, "R8 hl form");
    // Mixed sweep
    for (int i = 0; i < 60; i++) begin
      logic [15:0] a;
      logic [15:0] b;
      a = 16'(i * 16'h2F3B + 16'h0777);
      b = 16'(i * 16'h91C5);
      drive(3'(i % 8), a, b, 8'(i * 37), 4'(i), "R8 sweep");
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang, exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule